// File: doc/BRIEF.md
# Register-Indirect Add Control Sequencer

This block is the hardwired control unit for a processor whose registers, ALU operand latch (Y), result latch (Z), memory address register (MAR) and memory data register (MDR) all share one internal bus. It walks through the six control steps of one instruction. That instruction reads the memory word addressed by a source general register and adds it into a destination general register. Each step drives exactly one word of control enables. These select the single bus driver, the latches that capture the bus, the memory read strobe and the ALU operation.

A step counter moves forward on every clock. There are two exceptions. In a step that must wait for memory, the counter stays put until the memory reports completion. The last step returns the counter to the first step and raises an instruction-done pulse one cycle later. The source and destination register indices are inputs. They pick which per-register output or input enable is driven in the steps that use a general register.

Top module: `ind_add_sequencer`

## Requirements
- R1: While reset is applied, and in the first cycle after its release, every control output and `instr_done` is 0. The counter then stands at step 1.
- R2: Step 1 drives `pc_out`, `mar_in`, `mem_rd`, `y_clr`, `cin_set`, `alu_add` and `z_in`. Every other control output is 0.
- R3: Step 2 drives `z_out`, `pc_in` and `wait_mem`. Every other control output is 0.
- R4: Step 3 drives `gpr_out` bit `src_idx`, `mar_in` and `mem_rd`. Every other control output is 0.
- R5: Step 4 drives `gpr_out` bit `dst_idx`, `y_in` and `wait_mem`. Every other control output is 0.
- R6: Step 5 drives `mdr_out`, `alu_add` and `z_in`. Every other control output is 0.
- R7: Step 6 drives `z_out`, `gpr_in` bit `dst_idx` and `end_step`. Every other control output is 0.
- R8: When `wait_mem` is 1 and `mem_done` is 0 at a clock edge, the counter holds, and the same step's control word is driven in the next cycle.
- R9: When `wait_mem` is 1 and `mem_done` is 1 at a clock edge, the counter moves to the next step. In steps without `wait_mem`, `mem_done` has no effect on the sequence.
- R10: The clock edge that ends step 6 returns the counter to step 1. `instr_done` is 1 for exactly the one cycle after step 6.
- R11: In every cycle, at most one bus driver is active among `pc_out`, `mdr_out`, `z_out` and the bits of `gpr_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_done | input | 1 | Memory has completed the pending access |
| src_idx | input | 3 | Index of the register that holds the operand address |
| dst_idx | input | 3 | Index of the accumulating destination register |
| pc_out | output | 1 | PC drives the bus |
| pc_in | output | 1 | PC captures the bus |
| mar_in | output | 1 | MAR captures the bus |
| mdr_out | output | 1 | MDR drives the bus |
| y_in | output | 1 | Y captures the bus |
| y_clr | output | 1 | Y is forced to zero |
| z_in | output | 1 | Z captures the ALU result |
| z_out | output | 1 | Z drives the bus |
| mem_rd | output | 1 | Memory read request |
| alu_add | output | 1 | ALU performs addition |
| cin_set | output | 1 | ALU carry-in forced to 1 |
| wait_mem | output | 1 | Step waits for memory completion |
| end_step | output | 1 | Final step of the instruction |
| gpr_out | output | 8 | Per-register bus driver enables |
| gpr_in | output | 8 | Per-register bus capture enables |
| instr_done | output | 1 | One-cycle pulse after the final step |

## Verification
The bench builds the block with its default eight registers, so the three-bit index inputs cover every register. The bench changes the indices every cycle. This brings in cases where source and destination are the same register, and index changes in the middle of an instruction. A bench-side pseudo-random source drives `mem_done`, and it also toggles in steps that do not wait. One phase holds memory completion low for many cycles. A reset in the middle of an instruction checks the return to the reset state.

// File: rtl/ind_add_seq_pkg.sv
`timescale 1ns/1ps
package ind_add_seq_pkg;

   localparam int NUM_STEPS = 6;
   localparam int STEP_W    = $clog2(NUM_STEPS);

   localparam logic [STEP_W-1:0] ST_FETCH  = STEP_W'(0);
   localparam logic [STEP_W-1:0] ST_PCUPD  = STEP_W'(1);
   localparam logic [STEP_W-1:0] ST_OPADDR = STEP_W'(2);
   localparam logic [STEP_W-1:0] ST_LOADY  = STEP_W'(3);
   localparam logic [STEP_W-1:0] ST_SUM    = STEP_W'(4);
   localparam logic [STEP_W-1:0] ST_WBACK  = STEP_W'(5);

   typedef struct packed {
      logic pc_out;
      logic pc_in;
      logic mar_in;
      logic mdr_out;
      logic y_in;
      logic y_clr;
      logic z_in;
      logic z_out;
      logic mem_rd;
      logic alu_add;
      logic cin_set;
      logic wait_mem;
      logic end_step;
      logic src_out;
      logic dst_out;
      logic dst_in;
   } ctl_word_t;

endpackage

// File: rtl/seq_step_counter.sv
`timescale 1ns/1ps
module seq_step_counter
   import ind_add_seq_pkg::*;
#(
   parameter int STEPS = NUM_STEPS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold,
   input  logic              last,
   output logic [STEP_W-1:0] step,
   output logic              armed
);

   localparam logic [STEP_W-1:0] FIRST = '0;

   if (STEPS != NUM_STEPS) begin : g_bad_steps
      $error("seq_step_counter: STEPS must equal the package step count");
   end

   logic [STEP_W-1:0] step_q;
   logic              armed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q  <= FIRST;
         armed_q <= 1'b0;
      end else if (!armed_q) begin
         armed_q <= 1'b1;
      end else if (last) begin
         step_q  <= FIRST;
      end else if (!hold) begin
         step_q  <= step_q + STEP_W'(1);
      end
   end

   assign step  = step_q;
   assign armed = armed_q;

   // R8
   hold_keeps_step_chk: assert property (@(posedge clk) disable iff (rst)
      (armed_q && hold && !last) |=> (step_q == $past(step_q)));

   // R9
   advance_step_chk: assert property (@(posedge clk) disable iff (rst)
      (armed_q && !hold && !last) |=> (step_q == $past(step_q) + STEP_W'(1)));

   // R10
   wrap_to_first_chk: assert property (@(posedge clk) disable iff (rst)
      (armed_q && last) |=> (step_q == FIRST));

endmodule

// File: rtl/seq_word_decoder.sv
`timescale 1ns/1ps
module seq_word_decoder
   import ind_add_seq_pkg::*;
(
   input  logic [STEP_W-1:0] step,
   input  logic              armed,
   output ctl_word_t         word
);

   always_comb begin
      word = '0;
      if (armed) begin
         case (step)
            ST_FETCH: begin
               word.pc_out  = 1'b1;
               word.mar_in  = 1'b1;
               word.mem_rd  = 1'b1;
               word.y_clr   = 1'b1;
               word.cin_set = 1'b1;
               word.alu_add = 1'b1;
               word.z_in    = 1'b1;
            end
            ST_PCUPD: begin
               word.z_out    = 1'b1;
               word.pc_in    = 1'b1;
               word.wait_mem = 1'b1;
            end
            ST_OPADDR: begin
               word.src_out = 1'b1;
               word.mar_in  = 1'b1;
               word.mem_rd  = 1'b1;
            end
            ST_LOADY: begin
               word.dst_out  = 1'b1;
               word.y_in     = 1'b1;
               word.wait_mem = 1'b1;
            end
            ST_SUM: begin
               word.mdr_out = 1'b1;
               word.alu_add = 1'b1;
               word.z_in    = 1'b1;
            end
            ST_WBACK: begin
               word.z_out    = 1'b1;
               word.dst_in   = 1'b1;
               word.end_step = 1'b1;
            end
            default: word = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpr_enable_decoder.sv
`timescale 1ns/1ps
module gpr_enable_decoder #(
   parameter int NUM_REGS = 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [IDX_W-1:0]    idx,
   input  logic                en,
   output logic [NUM_REGS-1:0] onehot
);

   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_regs
      $error("gpr_enable_decoder: NUM_REGS must be a power of two, at least 2");
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
      assign onehot[i] = en && (idx == IDX_W'(i));
   end

endmodule

// File: rtl/ind_add_sequencer.sv
`timescale 1ns/1ps
module ind_add_sequencer
   import ind_add_seq_pkg::*;
#(
   parameter int NUM_REGS = 8,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                mem_done,
   input  logic [IDX_W-1:0]    src_idx,
   input  logic [IDX_W-1:0]    dst_idx,
   output logic                pc_out,
   output logic                pc_in,
   output logic                mar_in,
   output logic                mdr_out,
   output logic                y_in,
   output logic                y_clr,
   output logic                z_in,
   output logic                z_out,
   output logic                mem_rd,
   output logic                alu_add,
   output logic                cin_set,
   output logic                wait_mem,
   output logic                end_step,
   output logic [NUM_REGS-1:0] gpr_out,
   output logic [NUM_REGS-1:0] gpr_in,
   output logic                instr_done
);

   if (NUM_REGS > 64) begin : g_too_many_regs
      $error("ind_add_sequencer: NUM_REGS above 64 is not supported");
   end

   logic [STEP_W-1:0]   step;
   logic                armed;
   ctl_word_t           word;
   logic                hold;
   logic [NUM_REGS-1:0] src_drv;
   logic [NUM_REGS-1:0] dst_drv;
   logic                done_q;

   assign hold = word.wait_mem && !mem_done;

   seq_step_counter #(.STEPS(NUM_STEPS)) u_counter (
      .clk   (clk),
      .rst   (rst),
      .hold  (hold),
      .last  (word.end_step),
      .step  (step),
      .armed (armed)
   );

   seq_word_decoder u_decode (
      .step  (step),
      .armed (armed),
      .word  (word)
   );

   gpr_enable_decoder #(.NUM_REGS(NUM_REGS)) u_src_out (
      .idx    (src_idx),
      .en     (word.src_out),
      .onehot (src_drv)
   );

   gpr_enable_decoder #(.NUM_REGS(NUM_REGS)) u_dst_out (
      .idx    (dst_idx),
      .en     (word.dst_out),
      .onehot (dst_drv)
   );

   gpr_enable_decoder #(.NUM_REGS(NUM_REGS)) u_dst_in (
      .idx    (dst_idx),
      .en     (word.dst_in),
      .onehot (gpr_in)
   );

   always_ff @(posedge clk) begin
      if (rst) done_q <= 1'b0;
      else     done_q <= word.end_step;
   end

   assign gpr_out    = src_drv | dst_drv;
   assign pc_out     = word.pc_out;
   assign pc_in      = word.pc_in;
   assign mar_in     = word.mar_in;
   assign mdr_out    = word.mdr_out;
   assign y_in       = word.y_in;
   assign y_clr      = word.y_clr;
   assign z_in       = word.z_in;
   assign z_out      = word.z_out;
   assign mem_rd     = word.mem_rd;
   assign alu_add    = word.alu_add;
   assign cin_set    = word.cin_set;
   assign wait_mem   = word.wait_mem;
   assign end_step   = word.end_step;
   assign instr_done = done_q;

   // R11
   single_bus_driver_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({pc_out, mdr_out, z_out, gpr_out}));

   // R10
   done_after_end_chk: assert property (@(posedge clk) disable iff (rst)
      end_step |=> instr_done);

   // R10
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      instr_done |=> !instr_done);

   // R8
   held_word_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (wait_mem && !mem_done) |=> ($stable({pc_in, y_in, z_out, wait_mem}) && wait_mem));

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> ({pc_out, mar_in, mem_rd, z_in, gpr_out, gpr_in, instr_done} == '0));

endmodule

// File: tb/ind_add_sequencer_test.sv
`timescale 1ns/1ps
module ind_add_sequencer_test;

   localparam int NREG = 8;
   localparam int IW   = 3;

   logic            clk = 1'b0;
   logic            rst;
   logic            mem_done;
   logic [IW-1:0]   src_idx;
   logic [IW-1:0]   dst_idx;
   logic            pc_out, pc_in, mar_in, mdr_out, y_in, y_clr, z_in, z_out;
   logic            mem_rd, alu_add, cin_set, wait_mem, end_step, instr_done;
   logic [NREG-1:0] gpr_out, gpr_in;

   always #10 clk = ~clk;

   ind_add_sequencer #(.NUM_REGS(NREG)) uut (
      .clk(clk), .rst(rst), .mem_done(mem_done),
      .src_idx(src_idx), .dst_idx(dst_idx),
      .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mdr_out(mdr_out),
      .y_in(y_in), .y_clr(y_clr), .z_in(z_in), .z_out(z_out),
      .mem_rd(mem_rd), .alu_add(alu_add), .cin_set(cin_set),
      .wait_mem(wait_mem), .end_step(end_step),
      .gpr_out(gpr_out), .gpr_in(gpr_in), .instr_done(instr_done)
   );

   int compared   = 0;
   int mismatched = 0;
   bit finished   = 0;

   // reference model state, steps numbered 1..6
   int m_step      = 1;
   bit m_armed     = 0;
   bit m_done      = 0;
   bit m_held      = 0;
   bit m_waitadv   = 0;
   int cyc         = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // order: pc_out pc_in mar_in mdr_out y_in y_clr z_in z_out mem_rd alu_add cin_set wait_mem end_step
   function automatic logic [12:0] exp_word(int s, bit a);
      if (!a) return '0;
      case (s)
         1: return 13'b1010011011100;
         2: return 13'b0100000100010;
         3: return 13'b0010000010000;
         4: return 13'b0000100000010;
         5: return 13'b0001001001000;
         6: return 13'b0000000100001;
         default: return '0;
      endcase
   endfunction

   function automatic string step_tag(int s);
      case (s)
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic run_cycle(bit rst_v, bit md, bit do_check);
      logic [NREG-1:0] e_out, e_in;
      string tag;
      logic [12:0] w;
      int drivers;
      @(negedge clk);
      rst      = rst_v;
      mem_done = md;
      src_idx  = IW'(cyc);
      dst_idx  = IW'(cyc * 3);
      #2;
      if (do_check) begin
         tag = !m_armed ? "R1" : m_held ? "R8" : m_waitadv ? "R9" : step_tag(m_step);
         w = exp_word(m_step, m_armed);
         e_out = '0;
         e_in  = '0;
         if (m_armed && m_step == 3) e_out[src_idx] = 1'b1;
         if (m_armed && m_step == 4) e_out[dst_idx] = 1'b1;
         if (m_armed && m_step == 6) e_in[dst_idx]  = 1'b1;
         check(tag, "control word",
               32'({pc_out, pc_in, mar_in, mdr_out, y_in, y_clr, z_in, z_out,
                    mem_rd, alu_add, cin_set, wait_mem, end_step}), 32'(w));
         check(tag, "gpr_out", 32'(gpr_out), 32'(e_out));
         check(tag, "gpr_in", 32'(gpr_in), 32'(e_in));
         check(m_armed ? "R10" : "R1", "instr_done", 32'(instr_done), 32'(m_done));
         drivers = $countones({pc_out, mdr_out, z_out, gpr_out});
         check("R11", "bus driver count <= 1", 32'(drivers > 1), 32'(0));
      end
      // model update for the coming clock edge
      if (rst_v) begin
         m_step = 1; m_armed = 0; m_done = 0; m_held = 0; m_waitadv = 0;
      end else if (!m_armed) begin
         m_armed = 1; m_done = 0; m_held = 0; m_waitadv = 0;
      end else begin
         m_done    = (m_step == 6);
         m_held    = 0;
         m_waitadv = 0;
         if (m_step == 6) m_step = 1;
         else if ((m_step == 2 || m_step == 4) && !md) m_held = 1;
         else begin
            m_waitadv = (m_step == 2 || m_step == 4);
            m_step = m_step + 1;
         end
      end
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   initial begin
      rst = 1'b1; mem_done = 1'b0; src_idx = '0; dst_idx = '0;
      run_cycle(1, 0, 0);
      run_cycle(1, 0, 0);
      run_cycle(1, 0, 1);                 // R1 during reset
      // fast memory: no holds
      for (int i = 0; i < 30; i++) run_cycle(0, 1, 1);
      // random completion, also toggling in non-wait steps (R9)
      for (int i = 0; i < 200; i++) run_cycle(0, lfsr[0] & lfsr[3], 1);
      // long memory stall (R8)
      for (int i = 0; i < 40; i++) run_cycle(0, (i % 13) == 12, 1);
      // reset in the middle of an instruction (R1)
      run_cycle(0, 1, 1);
      run_cycle(0, 1, 1);
      run_cycle(1, 1, 1);
      run_cycle(1, 0, 1);
      for (int i = 0; i < 60; i++) run_cycle(0, lfsr[1] | lfsr[5], 1);
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule